// File: doc/BRIEF.md
# Transition-Coded Framed Serial Link

This block pairs a transmitter and a receiver that move framed 32-bit payload words over one two-level wire. Software-side logic loads payload words through a write port into a small queue and then pulses a start strobe. The transmitter sends one frame built from four parts:

- an opening marker word,
- a length word giving the number of queued payload words,
- the payload words themselves,
- the marker word again.

Every bit is carried as a level change in the middle of a cell two half-periods long. A rising change means 1 and a falling change means 0. The most significant bit goes out first.

The receiver does not recover a clock. It passes the wire through a two-flop synchroniser and compares successive samples taken at a fixed poll interval. When the level rises it decides a 1, and when it falls it decides a 0. After each decided bit it ignores changes for one and a half half-periods. This skips the change that can sit on the boundary between two cells.

The receiver hunts for the marker in a sliding 32-bit window. It then reads the length and delivers each payload word as a one-cycle strobe. Finally it reports either a good frame or a framing error, depending on whether the closing marker matches.

Top module: `trlink_top`

## Requirements
- R1: After reset and whenever no frame is in flight, `line_out` is 0 and `tx_busy` is 0; the receiver strobes `rx_word_valid`, `rx_frame_ok` and `rx_error` stay 0 until a frame is decoded.
- R2: A frame sends, in order: 0xAAAAAAAA, then a 32-bit length equal to the number of words queued when `start` was accepted, then those words in write order, then 0xAAAAAAAA again.
- R3: Each bit is a cell of 2*HALF_CYC clocks. A 1 is low for HALF_CYC clocks then high for HALF_CYC clocks. A 0 is high then low. Bit 31 goes first. The first level appears in the cycle after the clock edge that accepts `start`. `tx_busy` stays 1 for exactly the length of the frame.
- R4: The payload queue holds FIFO_DEPTH words. `wr_full` is 1 while it holds FIFO_DEPTH words, and a write while full is dropped and changes no later frame.
- R5: The receiver samples the synchronised line every POLL_CYC clocks. A low-to-high change between samples yields bit 1 and a high-to-low change yields bit 0. A change seen within (3*HALF_CYC)/2 clocks of the last decided bit is ignored, so runs of equal bits decode correctly.
- R6: Until the last 32 decoded bits equal 0xAAAAAAAA, decoded bits produce no output; bits decoded before the marker are discarded.
- R7: After the marker, the next 32 bits are the length N, and the next N 32-bit groups are each output once on `rx_word` with a one-cycle `rx_word_valid` pulse, in order.
- R8: The 32 bits after the payload are compared with 0xAAAAAAAA. On a match `rx_frame_ok` pulses for one cycle, otherwise `rx_error` pulses for one cycle. The two never pulse together, and the receiver then returns to hunting.
- R9: A start with an empty queue sends a frame with length 0, which the receiver accepts with `rx_frame_ok` and no payload word.
- R10: `cfg_error` is 1 exactly when POLL_CYC >= HALF_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the payload queue |
| wr_data | input | 32 | Payload word to queue |
| wr_full | output | 1 | Payload queue holds FIFO_DEPTH words |
| start | input | 1 | Begin sending a frame (accepted when idle) |
| tx_busy | output | 1 | Frame in flight |
| line_out | output | 1 | Transition-coded transmit wire |
| line_in | input | 1 | Receive wire, may be asynchronous |
| rx_word_valid | output | 1 | One-cycle strobe for a received payload word |
| rx_word | output | 32 | Received payload word |
| rx_frame_ok | output | 1 | Closing marker matched |
| rx_error | output | 1 | Closing marker missing |
| cfg_error | output | 1 | Poll interval not shorter than the half-period |

## Verification
The bench builds the link with HALF_CYC=8, POLL_CYC=3 and FIFO_DEPTH=4. A queue that small fills within a few writes, so both the full flag and the dropped write can be seen. A poll interval of three clocks jitters the sample points by up to two clocks on either side of every change, which tests the boundary-blanking window against changes that arrive both early and late. A second copy, built with POLL_CYC equal to HALF_CYC=4, exposes the configuration flag. Frames that the bench drives onto the receive wire itself cover hunting after leading garbage and a corrupted closing marker.

// File: rtl/trlink_pkg.sv
package trlink_pkg;

    localparam int          WORD_W      = 32;
    localparam logic [31:0] MARKER_WORD = 32'hAAAA_AAAA;

    typedef enum logic [1:0] {
        SEG_HEAD,
        SEG_LEN,
        SEG_DATA,
        SEG_TAIL
    } tx_seg_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_LEN,
        RX_DATA,
        RX_TAIL
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic value;
    } rx_bit_t;

    // Level held during the first half of a bit cell.
    function automatic logic lead_level(input logic b);
        return ~b;
    endfunction

    function automatic int blank_cycles(input int half_cyc);
        return (3 * half_cyc) / 2;
    endfunction

endpackage

// File: rtl/trlink_fifo.sv
module trlink_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          push_ok, pop_ok;

    assign full    = (count_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (count_q != '0);
    assign dout    = mem[rd_ptr_q];
    assign count   = count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> count_q != '0);  // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));  // R4

endmodule

// File: rtl/trlink_tx.sv
module trlink_tx
    import trlink_pkg::*;
#(
    parameter int HALF_CYC   = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              start,
    output logic              busy,
    output logic              line
);
    localparam int TW = $clog2(HALF_CYC);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [WORD_W-1:0] q_dout;
    logic [CW-1:0]     q_count;
    logic              q_pop;

    logic              busy_q, line_q, half_q;
    logic [WORD_W-1:0] sh_q;
    logic [4:0]        bit_idx_q;
    logic [TW-1:0]     tcnt_q;
    tx_seg_e           seg_q;
    logic [CW-1:0]     left_q;

    tx_seg_e           nxt_seg;
    logic [WORD_W-1:0] nxt_word;
    logic [CW-1:0]     nxt_left;
    logic              want_pop;
    logic              half_end, cell_end, frame_end;

    trlink_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (q_pop),
        .dout  (q_dout),
        .count (q_count),
        .full  (wr_full)
    );

    assign half_end  = busy_q && (tcnt_q == TW'(HALF_CYC - 1));
    assign cell_end  = half_end && half_q;
    assign frame_end = cell_end && (bit_idx_q == '0) && (seg_q == SEG_TAIL);
    assign q_pop     = cell_end && want_pop;

    // Choose what to shift next at a cell boundary.
    always_comb begin
        nxt_seg  = seg_q;
        nxt_word = sh_q << 1;
        nxt_left = left_q;
        want_pop = 1'b0;
        if (bit_idx_q == '0) begin
            unique case (seg_q)
                SEG_HEAD: begin
                    nxt_seg  = SEG_LEN;
                    nxt_word = WORD_W'(left_q);
                end
                SEG_LEN, SEG_DATA: begin
                    if (left_q != '0) begin
                        nxt_seg  = SEG_DATA;
                        nxt_word = q_dout;
                        nxt_left = left_q - 1'b1;
                        want_pop = 1'b1;
                    end else begin
                        nxt_seg  = SEG_TAIL;
                        nxt_word = MARKER_WORD;
                    end
                end
                SEG_TAIL: begin
                    nxt_seg  = SEG_TAIL;
                    nxt_word = MARKER_WORD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            line_q    <= 1'b0;
            half_q    <= 1'b0;
            sh_q      <= '0;
            bit_idx_q <= '0;
            tcnt_q    <= '0;
            seg_q     <= SEG_HEAD;
            left_q    <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q    <= 1'b1;
                seg_q     <= SEG_HEAD;
                sh_q      <= MARKER_WORD;
                bit_idx_q <= 5'd31;
                half_q    <= 1'b0;
                tcnt_q    <= '0;
                left_q    <= q_count;
                line_q    <= lead_level(MARKER_WORD[31]);
            end
        end else if (half_end) begin
            tcnt_q <= '0;
            if (!half_q) begin
                half_q <= 1'b1;
                line_q <= sh_q[31];
            end else if (frame_end) begin
                half_q <= 1'b0;
                busy_q <= 1'b0;
                line_q <= 1'b0;
            end else begin
                half_q    <= 1'b0;
                sh_q      <= nxt_word;
                seg_q     <= nxt_seg;
                left_q    <= nxt_left;
                bit_idx_q <= bit_idx_q - 1'b1;
                line_q    <= lead_level(nxt_word[31]);
            end
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign line = line_q;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !line_q);  // R1
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && tcnt_q != '0) |-> line_q == $past(line_q));  // R3

endmodule

// File: rtl/trlink_sync.sv
module trlink_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

endmodule

// File: rtl/trlink_edge_sampler.sv
module trlink_edge_sampler
    import trlink_pkg::*;
#(
    parameter int HALF_CYC = 8,
    parameter int POLL_CYC = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    level_in,
    output rx_bit_t bit_o
);
    localparam int BLANK = blank_cycles(HALF_CYC);
    localparam int PW    = $clog2(POLL_CYC + 1);
    localparam int BW    = $clog2(BLANK + 1);

    logic [PW-1:0] poll_q;
    logic [BW-1:0] blank_q;
    logic          prev_q;
    rx_bit_t       bit_q;
    logic          tick;

    assign tick = (poll_q == PW'(POLL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_q  <= '0;
            blank_q <= '0;
            prev_q  <= 1'b0;
            bit_q   <= '0;
        end else begin
            bit_q.valid <= 1'b0;
            poll_q      <= tick ? '0 : poll_q + 1'b1;
            if (blank_q != '0) blank_q <= blank_q - 1'b1;
            if (tick) begin
                prev_q <= level_in;
                if ((level_in != prev_q) && (blank_q == '0)) begin
                    bit_q.valid <= 1'b1;
                    bit_q.value <= level_in;
                    blank_q     <= BW'(BLANK);
                end
            end
        end
    end

    assign bit_o = bit_q;

    AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
        bit_q.valid |=> !bit_q.valid);  // R5

endmodule

// File: rtl/trlink_rx_framer.sv
module trlink_rx_framer
    import trlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_bit_t           bit_i,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic              frame_ok,
    output logic              frame_err
);
    rx_state_e         state_q;
    logic [WORD_W-1:0] sh_q, left_q, word_q;
    logic [4:0]        cnt_q;
    logic              wv_q, ok_q, err_q;
    logic [WORD_W-1:0] shin;

    assign shin = {sh_q[WORD_W-2:0], bit_i.value};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HUNT;
            sh_q    <= '0;
            left_q  <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            wv_q    <= 1'b0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            wv_q  <= 1'b0;
            ok_q  <= 1'b0;
            err_q <= 1'b0;
            if (bit_i.valid) begin
                sh_q <= shin;
                if (state_q == RX_HUNT) begin
                    if (shin == MARKER_WORD) begin
                        state_q <= RX_LEN;
                        cnt_q   <= '0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == 5'd31) begin
                        unique case (state_q)
                            RX_LEN: begin
                                left_q  <= shin;
                                state_q <= (shin == '0) ? RX_TAIL : RX_DATA;
                            end
                            RX_DATA: begin
                                word_q <= shin;
                                wv_q   <= 1'b1;
                                left_q <= left_q - 1'b1;
                                if (left_q == WORD_W'(1)) state_q <= RX_TAIL;
                            end
                            RX_TAIL: begin
                                if (shin == MARKER_WORD) ok_q <= 1'b1;
                                else                     err_q <= 1'b1;
                                state_q <= RX_HUNT;
                                sh_q    <= '0;
                            end
                            default: state_q <= RX_HUNT;
                        endcase
                    end
                end
            end
        end
    end

    assign word_valid = wv_q;
    assign word       = word_q;
    assign frame_ok   = ok_q;
    assign frame_err  = err_q;

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ok_q && err_q));  // R8
    AST_WORD_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        wv_q |-> $past(state_q) == RX_DATA);  // R7
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == RX_HUNT) |-> !(wv_q || ok_q || err_q));  // R6

endmodule

// File: rtl/trlink_top.sv
module trlink_top
    import trlink_pkg::*;
#(
    parameter int HALF_CYC   = 8,
    parameter int POLL_CYC   = 3,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        wr_full,
    input  logic        start,
    output logic        tx_busy,
    output logic        line_out,
    input  logic        line_in,
    output logic        rx_word_valid,
    output logic [31:0] rx_word,
    output logic        rx_frame_ok,
    output logic        rx_error,
    output logic        cfg_error
);
    logic    line_sync;
    rx_bit_t rx_bit;

    assign cfg_error = (POLL_CYC >= HALF_CYC);

    trlink_tx #(.HALF_CYC(HALF_CYC), .FIFO_DEPTH(FIFO_DEPTH)) tx_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_full (wr_full),
        .start   (start),
        .busy    (tx_busy),
        .line    (line_out)
    );

    trlink_sync sync_i (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_sync)
    );

    trlink_edge_sampler #(.HALF_CYC(HALF_CYC), .POLL_CYC(POLL_CYC)) samp_i (
        .clk      (clk),
        .rst      (rst),
        .level_in (line_sync),
        .bit_o    (rx_bit)
    );

    trlink_rx_framer framer_i (
        .clk        (clk),
        .rst        (rst),
        .bit_i      (rx_bit),
        .word_valid (rx_word_valid),
        .word       (rx_word),
        .frame_ok   (rx_frame_ok),
        .frame_err  (rx_error)
    );

endmodule

// File: tb/trlink_top_tb_top.sv
module trlink_top_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          HALF       = 8;
    localparam int          POLL       = 3;
    localparam int          DEPTH      = 4;
    localparam logic [31:0] MARK       = 32'hAAAA_AAAA;

    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, start = 1'b0;
    logic        ovr_en = 1'b0, ovr_val = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full, tx_busy, line_out, line_in;
    logic        rx_word_valid, rx_frame_ok, rx_error, cfg_error;
    logic [31:0] rx_word;
    logic        c_full, c_busy, c_line, c_wv, c_ok, c_err, c_cfg;
    logic [31:0] c_word;

    int checks = 0, errors = 0;
    int ok_seen = 0, err_seen = 0, words_seen = 0;
    bit mon_on = 1'b0, finished = 1'b0;

    bit          exp_lv[$];
    logic [31:0] fifo_m[$];
    logic [33:0] exp_rx[$];
    int          m_n;
    logic [31:0] m_w;
    logic [33:0] ev;
    bit          e;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign line_in = ovr_en ? ovr_val : line_out;

    trlink_top #(.HALF_CYC(HALF), .POLL_CYC(POLL), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .start(start), .tx_busy(tx_busy), .line_out(line_out), .line_in(line_in),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_frame_ok(rx_frame_ok),
        .rx_error(rx_error), .cfg_error(cfg_error)
    );

    trlink_top #(.HALF_CYC(4), .POLL_CYC(4), .FIFO_DEPTH(2)) cfg_i (
        .clk(clk), .rst(rst), .wr_en(1'b0), .wr_data(32'd0), .wr_full(c_full),
        .start(1'b0), .tx_busy(c_busy), .line_out(c_line), .line_in(1'b0),
        .rx_word_valid(c_wv), .rx_word(c_word), .rx_frame_ok(c_ok),
        .rx_error(c_err), .cfg_error(c_cfg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void lv(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            for (int k = 0; k < HALF; k++) exp_lv.push_back(~w[i]);
            for (int k = 0; k < HALF; k++) exp_lv.push_back(w[i]);
        end
    endfunction

    // Reference model of the transmitter and the expected receiver events.
    always @(posedge clk) begin
        if (!rst) begin
            if (start && exp_lv.size() == 0) begin
                m_n = fifo_m.size();
                lv(MARK);
                lv(32'(m_n));
                for (int k = 0; k < m_n; k++) begin
                    m_w = fifo_m.pop_front();
                    lv(m_w);
                    exp_rx.push_back({2'd0, m_w});
                end
                lv(MARK);
                exp_rx.push_back({2'd1, 32'd0});
            end
            if (wr_en && fifo_m.size() < DEPTH) fifo_m.push_back(wr_data);
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_lv.size() > 0) begin
                e = exp_lv.pop_front();
                chk(line_out == e && tx_busy, "R3", "line level / busy in frame",
                    {30'd0, tx_busy, line_out}, {30'd0, 1'b1, e});
            end else begin
                chk(!line_out && !tx_busy, "R1", "idle line / busy",
                    {30'd0, tx_busy, line_out}, 32'd0);
            end
            if (rx_word_valid) begin
                words_seen++;
                if (exp_rx.size() == 0) chk(1'b0, "R7", "unexpected word", rx_word, 32'd0);
                else begin
                    ev = exp_rx.pop_front();
                    chk(ev[33:32] == 2'd0 && ev[31:0] == rx_word, "R7", "payload word",
                        rx_word, ev[31:0]);
                end
            end
            if (rx_frame_ok) begin
                ok_seen++;
                if (exp_rx.size() == 0) chk(1'b0, "R8", "unexpected frame ok", 32'd1, 32'd0);
                else begin
                    ev = exp_rx.pop_front();
                    chk(ev[33:32] == 2'd1, "R8", "frame ok event", 32'd1, {30'd0, ev[33:32]});
                end
            end
            if (rx_error) begin
                err_seen++;
                if (exp_rx.size() == 0) chk(1'b0, "R8", "unexpected error", 32'd2, 32'd0);
                else begin
                    ev = exp_rx.pop_front();
                    chk(ev[33:32] == 2'd2, "R8", "error event", 32'd2, {30'd0, ev[33:32]});
                end
            end
        end
    end

    task automatic wr(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while ((tx_busy || exp_rx.size() != 0 || exp_lv.size() != 0) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(t < 20000, req, "frame completed", t, 20000);
    endtask

    task automatic ovr_bit(input logic b);
        ovr_val = ~b;
        repeat (HALF) @(negedge clk);
        ovr_val = b;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic ovr_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) ovr_bit(w[i]);
    endtask

    task automatic ovr_garbage();
        for (int i = 0; i < 8; i++) ovr_bit(1'b0);
        ovr_val = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        int prev_ok, prev_err, prev_words;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!line_out && !tx_busy && !wr_full, "R1", "reset state tx",
            {29'd0, wr_full, tx_busy, line_out}, 32'd0);
        chk(!rx_word_valid && !rx_frame_ok && !rx_error, "R1", "reset state rx",
            {29'd0, rx_word_valid, rx_frame_ok, rx_error}, 32'd0);
        chk(cfg_error == 1'b0, "R10", "cfg ok for poll 3 < half 8", {31'd0, cfg_error}, 32'd0);
        chk(c_cfg == 1'b1, "R10", "cfg flagged for poll 4 >= half 4", {31'd0, c_cfg}, 32'd1);
        mon_on = 1'b1;

        // R2: three-word frame in loopback
        wr(32'h1234_5678);
        wr(32'hCAFE_F00D);
        wr(32'h0F0F_0F0F);
        chk(!wr_full, "R4", "not full at 3 of 4", {31'd0, wr_full}, 32'd0);
        prev_ok = ok_seen;
        do_start();
        wait_idle("R2");
        chk(ok_seen == prev_ok + 1, "R2", "frame accepted", ok_seen, prev_ok + 1);

        // R9: zero-length frame
        prev_ok = ok_seen; prev_words = words_seen;
        do_start();
        wait_idle("R9");
        chk(ok_seen == prev_ok + 1 && words_seen == prev_words, "R9",
            "empty frame ok, no words", words_seen - prev_words, 0);

        // R4, R5: full queue, dropped write, runs of equal bits
        wr(32'hFFFF_FFFF);
        wr(32'h0000_0000);
        wr(32'h8000_0001);
        wr(32'h7FFF_FFFE);
        chk(wr_full, "R4", "full at depth", {31'd0, wr_full}, 32'd1);
        wr(32'hBADB_AD00);
        chk(wr_full, "R4", "still full after dropped write", {31'd0, wr_full}, 32'd1);
        prev_words = words_seen;
        do_start();
        wait_idle("R5");
        chk(words_seen == prev_words + 4, "R4", "frame carries only queued words",
            words_seen - prev_words, 4);
        chk(!wr_full, "R4", "queue drained", {31'd0, wr_full}, 32'd0);

        // R6, R8: leading garbage, then a frame with a bad closing marker
        prev_err = err_seen;
        exp_rx.push_back({2'd0, 32'hDEAD_BEEF});
        exp_rx.push_back({2'd2, 32'd0});
        ovr_en = 1'b1;
        ovr_val = 1'b0;
        ovr_garbage();
        ovr_word(MARK);
        ovr_word(32'd1);
        ovr_word(32'hDEAD_BEEF);
        ovr_word(32'h1234_5678);
        ovr_val = 1'b0;
        ovr_en = 1'b0;
        wait_idle("R8");
        chk(err_seen == prev_err + 1, "R8", "bad closing marker flagged", err_seen, prev_err + 1);

        // R6: garbage then a good two-word frame
        prev_ok = ok_seen;
        exp_rx.push_back({2'd0, 32'h0123_4567});
        exp_rx.push_back({2'd0, 32'h89AB_CDEF});
        exp_rx.push_back({2'd1, 32'd0});
        ovr_en = 1'b1;
        ovr_val = 1'b0;
        ovr_garbage();
        ovr_word(MARK);
        ovr_word(32'd2);
        ovr_word(32'h0123_4567);
        ovr_word(32'h89AB_CDEF);
        ovr_word(MARK);
        ovr_val = 1'b0;
        ovr_en = 1'b0;
        wait_idle("R6");
        chk(ok_seen == prev_ok + 1, "R6", "frame found after garbage", ok_seen, prev_ok + 1);

        chk(exp_rx.size() == 0, "R7", "all expected events seen", exp_rx.size(), 0);
        mon_on = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule